// File: doc/BRIEF.md
# Predictive Program-Verify Sequencer

This block programs a group of multi-level nonvolatile cells in parallel, each to its own digital level. A full pulse-and-verify loop would read every cell after every pulse. This sequencer reads far less often. After checking that every cell starts inside the erased window, it sends a short fixed burst of calibration pulses and reads each cell once. From that one reading it works out each cell's slope in code units per pulse and divides the remaining distance to the target by it. It then sends that many pulses open-loop. A few verify-and-trim rounds finish the job.

The pulse generator, sense amplifier and converter sit outside the block. The block raises one strobe per cell for each programming pulse. It requests a verify and takes back one digitized threshold per cell with an acknowledge. When the run finishes, each cell reports a verdict.

Top module: `pvs_seq`

## Requirements
- R1: When `start` is seen while idle, `busy` rises on the next cycle and the first action is a verify request, with no pulse before it. A `start` seen while busy is ignored. After reset `busy`, `done`, `verify_req`, `pulse_stb` and `cell_status` are all zero.
- R2: A cell whose first reading is below `erase_lo` or above `erase_hi` gets status 4 (erase fault) and is never pulsed. Both limits are inclusive.
- R3: Each enabled cell that passes the erase check receives exactly CAL_PULSES (= 2^CAL_SH, default 4) pulses, and then one verify follows.
- R4: The target code is `level << (TH_W-LVL_W)`. The slope is `(v_cal - v_erase) >> CAL_SH`, with a slope of 0 treated as 1. A still-short cell then receives exactly `floor((target - v_cal)/slope)` pulses with no verify between the calibration verify and the next one.
- R5: A reading within `tol` of the target, inclusive on both sides, gives status 1 (pass), and the cell gets no further pulses.
- R6: A reading above `target + tol` gives status 3 (overshoot), and the cell gets no further pulses.
- R7: A cell still short after the open-loop burst gets one pulse per trim round, and each round is followed by one verify. If the cell is still short at the verify after MAX_TRIM rounds, it gets status 2 (short).
- R8: The number of verifies in a run is 1, plus 1 if any cell passed the erase check, plus 1 if any cell was still short after calibration, plus the number of trim rounds. While `verify_req` is high, no pulse strobe is high.
- R9: `done` is high for exactly one cycle per run, and `busy` is low on the cycle after it. A disabled cell keeps status 0 and is never pulsed.
- R10: A cell that is already within tolerance at the calibration verify passes with zero open-loop pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| cell_en | input | NCELL | Per-cell enable, captured at start |
| target_lvl | input | NCELL*LVL_W | Per-cell target level, captured at start |
| tol | input | TH_W | Accepted distance from target in codes, captured at start |
| erase_lo | input | TH_W | Lowest acceptable erased threshold code |
| erase_hi | input | TH_W | Highest acceptable erased threshold code |
| pulse_stb | output | NCELL | One-cycle programming pulse per cell |
| verify_req | output | 1 | One-cycle request for a threshold read |
| verify_ack | input | 1 | Read result valid on `vth` |
| vth | input | NCELL*TH_W | Digitized thresholds, one field per cell |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run flag |
| cell_status | output | NCELL*3 | Per-cell verdict: 0 none, 1 pass, 2 short, 3 overshoot, 4 erase fault |

## Verification
The bench models each cell with one step size during calibration and another afterwards. This makes the prediction miss on purpose, and it drives cells into trims, overshoot and trim exhaustion. A design that ignored the step change would show wrong pulse counts between the calibration and open-loop verifies. A design that kept pulsing a cell after overshoot would show extra pulses.

The erase limits are tested exactly at and one code past each bound. An off-by-one compare would either flag or keep the wrong cell. A cell with a flat calibration reading tests the divide-by-zero guard. A cell that lands on target at calibration must get zero open-loop pulses. Verify counts are checked against the rule in R8, so a redundant verify round or a missing one shows up. A second `start` is issued mid-run, and the bench checks that it neither restarts the run nor produces a second `done`.

// File: rtl/pvs_pkg.sv
// Shared types for the predictive program-verify sequencer.
// Assumes: cell verdicts fit in three bits; controller state fits in four bits.
package pvs_pkg;

    localparam int ST_W = 3;

    typedef enum logic [2:0] {
        ST_NONE  = 3'd0,
        ST_PASS  = 3'd1,
        ST_SHORT = 3'd2,
        ST_OVER  = 3'd3,
        ST_ERASE = 3'd4
    } cell_st_t;

    typedef enum logic [1:0] {
        VK_ERASE = 2'd0,
        VK_CAL   = 2'd1,
        VK_FIN   = 2'd2
    } vkind_t;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_VREQ  = 4'd1,
        S_VWAIT = 4'd2,
        S_CHK   = 4'd3,
        S_CAL   = 4'd4,
        S_DGO   = 4'd5,
        S_DWAIT = 4'd6,
        S_FF    = 4'd7,
        S_TRIM  = 4'd8,
        S_FIN   = 4'd9
    } ctl_st_t;

endpackage

// File: rtl/pvs_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Does: quo = floor(num/den) after W cycles of busy.
// Assumes: den is non-zero when go is raised; go is only raised while idle.
module pvs_div #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q, num_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W:0]    shifted;
    logic          fits;

    // Shift the next dividend bit into the partial remainder and test it.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = shifted >= {1'b0, den_q};
    end

    // Iterate the restoring division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (go) begin
            rem_q  <= '0;
            quo_q  <= num;
            den_q  <= den;
            num_q  <= num;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            rem_q <= fits ? W'(shifted - {1'b0, den_q}) : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign quo  = quo_q;

    logic [2*W:0] prod_lo, prod_hi;
    assign prod_lo = (2*W+1)'(quo_q) * (2*W+1)'(den_q);
    assign prod_hi = prod_lo + (2*W+1)'(den_q);

    // R4: a new division never starts on top of a running one
    a_r4_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q);

    // R4: the finished quotient is the floor of num/den
    a_r4_quotient_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (prod_lo <= (2*W+1)'(num_q)) && (prod_hi > (2*W+1)'(num_q)));

endmodule

// File: rtl/pvs_cell.sv
// Per-cell state of the sequencer: erase check, slope capture, pulse
// prediction and verdict.
// Assumes: vth is valid whenever a capture/eval strobe is high; the
// threshold only rises with pulses.
module pvs_cell
    import pvs_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int TH_W   = 10,
    parameter int CAL_SH = 2,
    parameter int CNT_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en_in,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic [TH_W-1:0]  tol,
    input  logic [TH_W-1:0]  lo,
    input  logic [TH_W-1:0]  hi,
    input  logic [TH_W-1:0]  vth,
    input  logic             cap_base,
    input  logic             cap_cal,
    input  logic             eval_fin,
    input  logic             trim_last,
    input  logic             div_go,
    input  logic             cal_ph,
    input  logic             ff_ph,
    input  logic             trim_ph,
    input  logic [CNT_W-1:0] ff_cnt,
    output logic             pulse,
    output logic             active,
    output logic             ff_more,
    output logic             div_busy,
    output logic [ST_W-1:0]  status
);
    localparam int SH = TH_W - LVL_W;

    logic            active_q, en_q;
    cell_st_t        status_q;
    logic [TH_W-1:0] tgt_q, base_q, vcal_q, slope_q;
    logic [TH_W-1:0] slope_calc, div_num, div_den, npred;
    logic [TH_W:0]   vth_x, tol_x, tgt_x;
    logic            is_over, is_short;

    // Compare the returned reading against the target band.
    always_comb begin
        vth_x    = {1'b0, vth};
        tol_x    = {1'b0, tol};
        tgt_x    = {1'b0, tgt_q};
        is_over  = vth_x > (tgt_x + tol_x);
        is_short = (vth_x + tol_x) < tgt_x;
    end

    // Slope per pulse from the calibration rise; a falling reading gives zero.
    always_comb begin
        slope_calc = (vth >= base_q) ? ((vth - base_q) >> CAL_SH) : '0;
    end

    // Divider operands: the remaining distance, and the slope with zero replaced by one.
    always_comb begin
        div_num = tgt_q - vcal_q;
        div_den = (slope_q == '0) ? TH_W'(1) : slope_q;
    end

    pvs_div #(.W(TH_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go && active_q),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .quo   (npred)
    );

    // Cell state across the phases of one run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            en_q     <= 1'b0;
            status_q <= ST_NONE;
            tgt_q    <= '0;
            base_q   <= '0;
            vcal_q   <= '0;
            slope_q  <= '0;
        end else if (clr) begin
            active_q <= en_in;
            en_q     <= en_in;
            status_q <= ST_NONE;
            tgt_q    <= TH_W'(lvl_in) << SH;
        end else if (cap_base && active_q) begin
            if (vth < lo || vth > hi) begin
                status_q <= ST_ERASE;
                active_q <= 1'b0;
            end else begin
                base_q <= vth;
            end
        end else if (cap_cal && active_q) begin
            vcal_q  <= vth;
            slope_q <= slope_calc;
            if (is_over) begin
                status_q <= ST_OVER;
                active_q <= 1'b0;
            end else if (!is_short) begin
                status_q <= ST_PASS;
                active_q <= 1'b0;
            end
        end else if (eval_fin && active_q) begin
            if (is_over) begin
                status_q <= ST_OVER;
                active_q <= 1'b0;
            end else if (!is_short) begin
                status_q <= ST_PASS;
                active_q <= 1'b0;
            end else if (trim_last) begin
                status_q <= ST_SHORT;
                active_q <= 1'b0;
            end
        end
    end

    // Pulse strobe: calibration and trim pulse every live cell; the burst runs to the predicted count.
    always_comb begin
        ff_more = active_q && (CNT_W'(npred) > ff_cnt);
        pulse   = active_q && (cal_ph || trim_ph || (ff_ph && ff_more));
    end

    assign active = active_q;
    assign status = status_q;

    // R5: once a verdict is recorded the cell receives no further pulses
    a_r5_verdict_stops_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != ST_NONE) |-> !pulse);

    // R6: an overshoot verdict is kept until the next run is accepted
    a_r6_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_OVER && !clr) |=> (status_q == ST_OVER));

    // R9: a disabled cell is never pulsed
    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pulse);

    // R2: an erase fault is never followed by a pass verdict in the same run
    a_r2_erase_final: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_ERASE && !clr) |=> (status_q == ST_ERASE));

endmodule

// File: rtl/pvs_ctrl.sv
// Run controller of the sequencer. It steps through the erase verify,
// calibration burst, calibration verify, division, open-loop burst and
// verify/trim rounds.
// Assumes: verify_ack arrives some cycles after verify_req; the cells report
// their aggregate activity back on the next cycle.
module pvs_ctrl
    import pvs_pkg::*;
#(
    parameter int CAL_SH   = 2,
    parameter int MAX_TRIM = 4,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             verify_ack,
    input  logic             any_active,
    input  logic             any_ff_more,
    input  logic             any_div_busy,
    output logic             clr,
    output logic             busy,
    output logic             done,
    output logic             verify_req,
    output logic             cap_base,
    output logic             cap_cal,
    output logic             eval_fin,
    output logic             trim_last,
    output logic             cal_ph,
    output logic             ff_ph,
    output logic             trim_ph,
    output logic             div_go,
    output logic [CNT_W-1:0] ff_cnt
);
    localparam int CAL_N = 1 << CAL_SH;
    localparam int CC_W  = CAL_SH + 1;
    localparam int TR_W  = $clog2(MAX_TRIM + 1) + 1;

    ctl_st_t          state_q;
    vkind_t           vkind_q;
    logic [CC_W-1:0]  cal_cnt_q;
    logic [TR_W-1:0]  trim_cnt_q;
    logic [CNT_W-1:0] ff_cnt_q;
    logic             strobe;

    // Phase sequencing for one programming run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            vkind_q    <= VK_ERASE;
            cal_cnt_q  <= '0;
            trim_cnt_q <= '0;
            ff_cnt_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_VREQ;
                    vkind_q <= VK_ERASE;
                end
                S_VREQ:  state_q <= S_VWAIT;
                S_VWAIT: if (verify_ack) state_q <= S_CHK;
                S_CHK: begin
                    case (vkind_q)
                        VK_ERASE: begin
                            cal_cnt_q <= '0;
                            state_q   <= any_active ? S_CAL : S_FIN;
                        end
                        VK_CAL:  state_q <= any_active ? S_DGO : S_FIN;
                        default: state_q <= any_active ? S_TRIM : S_FIN;
                    endcase
                end
                S_CAL: begin
                    if (cal_cnt_q == CC_W'(CAL_N - 1)) begin
                        state_q <= S_VREQ;
                        vkind_q <= VK_CAL;
                    end else begin
                        cal_cnt_q <= cal_cnt_q + 1'b1;
                    end
                end
                S_DGO: state_q <= S_DWAIT;
                S_DWAIT: if (!any_div_busy) begin
                    state_q  <= S_FF;
                    ff_cnt_q <= '0;
                end
                S_FF: begin
                    if (any_ff_more) begin
                        ff_cnt_q <= ff_cnt_q + 1'b1;
                    end else begin
                        state_q    <= S_VREQ;
                        vkind_q    <= VK_FIN;
                        trim_cnt_q <= '0;
                    end
                end
                S_TRIM: begin
                    trim_cnt_q <= trim_cnt_q + 1'b1;
                    state_q    <= S_VREQ;
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Decode phase strobes for the cells and the block outputs.
    always_comb begin
        strobe     = (state_q == S_VWAIT) && verify_ack;
        clr        = (state_q == S_IDLE) && start;
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_FIN);
        verify_req = (state_q == S_VREQ);
        cap_base   = strobe && (vkind_q == VK_ERASE);
        cap_cal    = strobe && (vkind_q == VK_CAL);
        eval_fin   = strobe && (vkind_q == VK_FIN);
        trim_last  = (trim_cnt_q == TR_W'(MAX_TRIM));
        cal_ph     = (state_q == S_CAL);
        ff_ph      = (state_q == S_FF);
        trim_ph    = (state_q == S_TRIM);
        div_go     = (state_q == S_DGO);
        ff_cnt     = ff_cnt_q;
    end

    // R7: never more trim rounds than allowed
    a_r7_trim_bound: assert property (@(posedge clk) disable iff (!rst_n)
        trim_cnt_q <= TR_W'(MAX_TRIM));

    // R9: done lasts one cycle and the block is idle afterwards
    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R1: an accepted start is followed by the erase verify request
    a_r1_erase_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> verify_req);

endmodule

// File: rtl/pvs_seq.sv
// Top of the predictive program-verify sequencer for NCELL cells.
// Does: captures the run settings, runs the controller, and instantiates one
// cell slice per programmed cell.
// Assumes: the external pulse generator acts on every high pulse_stb bit;
// vth holds one TH_W code per cell.
module pvs_seq
    import pvs_pkg::*;
#(
    parameter int NCELL    = 8,
    parameter int LVL_W    = 6,
    parameter int TH_W     = 10,
    parameter int CAL_SH   = 2,
    parameter int MAX_TRIM = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NCELL-1:0]      cell_en,
    input  logic [NCELL*LVL_W-1:0] target_lvl,
    input  logic [TH_W-1:0]       tol,
    input  logic [TH_W-1:0]       erase_lo,
    input  logic [TH_W-1:0]       erase_hi,
    output logic [NCELL-1:0]      pulse_stb,
    output logic                  verify_req,
    input  logic                  verify_ack,
    input  logic [NCELL*TH_W-1:0] vth,
    output logic                  busy,
    output logic                  done,
    output logic [NCELL*ST_W-1:0] cell_status
);
    localparam int CNT_W = TH_W + 1;

    logic [TH_W-1:0]  tol_q, lo_q, hi_q;
    logic [NCELL-1:0] act_v, more_v, dbusy_v;
    logic             clr, cap_base, cap_cal, eval_fin, trim_last;
    logic             cal_ph, ff_ph, trim_ph, div_go;
    logic [CNT_W-1:0] ff_cnt;

    // Hold the tolerance and erase window fixed for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tol_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (clr) begin
            tol_q <= tol;
            lo_q  <= erase_lo;
            hi_q  <= erase_hi;
        end
    end

    pvs_ctrl #(.CAL_SH(CAL_SH), .MAX_TRIM(MAX_TRIM), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .verify_ack   (verify_ack),
        .any_active   (|act_v),
        .any_ff_more  (|more_v),
        .any_div_busy (|dbusy_v),
        .clr          (clr),
        .busy         (busy),
        .done         (done),
        .verify_req   (verify_req),
        .cap_base     (cap_base),
        .cap_cal      (cap_cal),
        .eval_fin     (eval_fin),
        .trim_last    (trim_last),
        .cal_ph       (cal_ph),
        .ff_ph        (ff_ph),
        .trim_ph      (trim_ph),
        .div_go       (div_go),
        .ff_cnt       (ff_cnt)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        pvs_cell #(.LVL_W(LVL_W), .TH_W(TH_W), .CAL_SH(CAL_SH), .CNT_W(CNT_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .en_in     (cell_en[c]),
            .lvl_in    (target_lvl[c*LVL_W +: LVL_W]),
            .tol       (tol_q),
            .lo        (lo_q),
            .hi        (hi_q),
            .vth       (vth[c*TH_W +: TH_W]),
            .cap_base  (cap_base),
            .cap_cal   (cap_cal),
            .eval_fin  (eval_fin),
            .trim_last (trim_last),
            .div_go    (div_go),
            .cal_ph    (cal_ph),
            .ff_ph     (ff_ph),
            .trim_ph   (trim_ph),
            .ff_cnt    (ff_cnt),
            .pulse     (pulse_stb[c]),
            .active    (act_v[c]),
            .ff_more   (more_v[c]),
            .div_busy  (dbusy_v[c]),
            .status    (cell_status[c*ST_W +: ST_W])
        );
    end

    // R8: reads and pulses never overlap
    a_r8_no_pulse_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req |-> (pulse_stb == '0));

endmodule

// File: tb/tb_pvs_seq.sv
module tb_pvs_seq;
    localparam int NC = 8, LW = 6, TW = 10, CSH = 2, MT = 4, CALN = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [NC-1:0] cell_en = '0;
    logic [NC*LW-1:0] target_lvl = '0;
    logic [TW-1:0] tol = '0, erase_lo = '0, erase_hi = '0;
    logic [NC-1:0] pulse_stb;
    logic verify_req, busy, done;
    logic verify_ack = 1'b0;
    logic [NC*TW-1:0] vth = '0;
    logic [NC*3-1:0] cell_status;

    always #5 clk = ~clk;

    pvs_seq #(.NCELL(NC), .LVL_W(LW), .TH_W(TW), .CAL_SH(CSH), .MAX_TRIM(MT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cell_en(cell_en),
        .target_lvl(target_lvl), .tol(tol), .erase_lo(erase_lo), .erase_hi(erase_hi),
        .pulse_stb(pulse_stb), .verify_req(verify_req), .verify_ack(verify_ack),
        .vth(vth), .busy(busy), .done(done), .cell_status(cell_status));

    int v0[NC], s1[NC], s2[NC], lvl[NC];
    bit en[NC];
    int tol_i, lo_i, hi_i;
    int vm[NC], pc[NC], snap[8][NC];
    int vcnt, done_cnt, wait_n;
    bit model_rst;
    int n_chk, n_bad;
    int e_st[NC], e_tot[NC], e_ff[NC], e_stage[NC];
    int e_ver, any_cal, any_ff;

    function automatic int clip(int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    // 0 short, 1 within band, 2 over
    function automatic int judge(int v, int t, int tl);
        if (v > t + tl) return 2;
        if (v + tl < t) return 0;
        return 1;
    endfunction

    // Cell model: the threshold rises by s1 per calibration pulse and by s2 afterwards.
    always @(posedge clk) begin
        if (model_rst) begin
            for (int c = 0; c < NC; c++) begin vm[c] <= v0[c]; pc[c] <= 0; end
            vcnt <= 0; done_cnt <= 0;
        end else begin
            for (int c = 0; c < NC; c++)
                if (pulse_stb[c]) begin
                    vm[c] <= clip(vm[c] + ((pc[c] < CALN) ? s1[c] : s2[c]));
                    pc[c] <= pc[c] + 1;
                end
            if (verify_req) begin
                if (vcnt < 8) for (int c = 0; c < NC; c++) snap[vcnt][c] <= pc[c];
                vcnt <= vcnt + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    // Read responder: returns the model thresholds a few cycles after a request.
    always @(negedge clk) begin
        verify_ack = 1'b0;
        if (verify_req) wait_n = 3;
        else if (wait_n > 0) begin
            wait_n = wait_n - 1;
            if (wait_n == 1) begin
                for (int c = 0; c < NC; c++) vth[c*TW +: TW] = TW'(vm[c]);
                verify_ack = 1'b1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compute_expected();
        int vc, sl, t, n, v, k, mtr;
        any_cal = 0; any_ff = 0; mtr = 0;
        for (int c = 0; c < NC; c++) begin
            e_ff[c] = 0; e_stage[c] = 0;
            if (!en[c]) begin e_st[c] = 0; e_tot[c] = 0; end
            else if (v0[c] < lo_i || v0[c] > hi_i) begin e_st[c] = 4; e_tot[c] = 0; end
            else begin
                any_cal = 1; e_stage[c] = 1;
                vc = clip(v0[c] + CALN * s1[c]);
                sl = (vc - v0[c]) >> CSH;
                t = lvl[c] << (TW - LW);
                if (judge(vc, t, tol_i) == 1) begin e_st[c] = 1; e_tot[c] = CALN; end
                else if (judge(vc, t, tol_i) == 2) begin e_st[c] = 3; e_tot[c] = CALN; end
                else begin
                    any_ff = 1; e_stage[c] = 2;
                    n = (t - vc) / ((sl == 0) ? 1 : sl);
                    v = clip(vc + n * s2[c]);
                    k = 0;
                    forever begin
                        if (judge(v, t, tol_i) == 1) begin e_st[c] = 1; break; end
                        if (judge(v, t, tol_i) == 2) begin e_st[c] = 3; break; end
                        if (k == MT) begin e_st[c] = 2; break; end
                        v = clip(v + s2[c]); k++;
                    end
                    e_ff[c] = n; e_tot[c] = CALN + n + k;
                    if (k > mtr) mtr = k;
                end
            end
        end
        e_ver = 1 + any_cal + any_ff + (any_ff ? mtr : 0);
    endtask

    task automatic run_case(string nm, bit restart);
        int cyc;
        for (int c = 0; c < NC; c++) begin
            cell_en[c] = en[c];
            target_lvl[c*LW +: LW] = LW'(lvl[c]);
        end
        tol = TW'(tol_i); erase_lo = TW'(lo_i); erase_hi = TW'(hi_i);
        @(negedge clk) model_rst = 1'b1;
        @(negedge clk) model_rst = 1'b0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check({nm, " R1 busy after start"}, int'(busy), 1);
        cyc = 0;
        while (done_cnt == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (restart && cyc == 30) start = 1'b1;
            if (restart && cyc == 31) start = 1'b0;
        end
        if (cyc >= 20000) check({nm, " watchdog"}, 0, 1);
        repeat (4) @(negedge clk);
        compute_expected();
        check({nm, " R9 busy low after done"}, int'(busy), 0);
        check({nm, " R9 single done"}, done_cnt, 1);
        check({nm, " R8 verify count"}, vcnt, e_ver);
        for (int c = 0; c < NC; c++) begin
            string tg;
            case (e_st[c]) 1: tg = "R5"; 2: tg = "R7"; 3: tg = "R6"; 4: tg = "R2"; default: tg = "R9"; endcase
            check($sformatf("%s %s status cell%0d", nm, tg, c), int'(cell_status[c*3 +: 3]), e_st[c]);
            check($sformatf("%s %s pulses cell%0d", nm, tg, c), pc[c], e_tot[c]);
            check($sformatf("%s R1 no pulse before first read cell%0d", nm, c), snap[0][c], 0);
            if (any_cal)
                check($sformatf("%s R3 calibration pulses cell%0d", nm, c), snap[1][c],
                      (e_stage[c] >= 1) ? CALN : 0);
            if (any_ff)
                check($sformatf("%s R4 open-loop pulses cell%0d", nm, c), snap[2][c] - snap[1][c], e_ff[c]);
        end
    endtask

    task automatic t_reset();
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset verify_req", int'(verify_req), 0);
        check("R1 reset pulses", int'(pulse_stb), 0);
        check("R1 reset status", int'(cell_status), 0);
    endtask

    task automatic t_nominal(bit restart);
        tol_i = 8; lo_i = 50; hi_i = 300;
        for (int c = 0; c < NC; c++) begin
            en[c] = 1; v0[c] = 60 + 15 * c; s1[c] = 4 + c; s2[c] = 4 + c; lvl[c] = 16 + 5 * c;
        end
        run_case(restart ? "restart" : "nominal", restart);
    endtask

    task automatic t_mismatch();
        tol_i = 2; lo_i = 0; hi_i = 1023;
        for (int c = 0; c < NC; c++) en[c] = 1;
        v0 = '{100, 60, 80, 90, 50, 70, 110, 130};
        s1 = '{8, 4, 6, 0, 10, 7, 3, 12};
        s2 = '{5, 12, 0, 3, 9, 7, 2, 11};
        lvl = '{20, 15, 25, 30, 40, 12, 18, 50};
        run_case("mismatch", 1'b0);
        check("R7 flat cell ends short", int'(cell_status[2*3 +: 3]), 2);
        check("R6 zero-slope cell overshoots", int'(cell_status[3*3 +: 3]), 3);
    endtask

    task automatic t_edges();
        tol_i = 4; lo_i = 100; hi_i = 200;
        en = '{1, 1, 1, 1, 0, 1, 1, 1};
        v0 = '{99, 100, 200, 201, 150, 120, 150, 130};
        s1 = '{5, 6, 5, 5, 5, 6, 20, 3};
        s2 = '{5, 6, 5, 5, 5, 6, 20, 4};
        lvl = '{20, 20, 30, 20, 20, 9, 10, 25};
        run_case("edges", 1'b0);
        check("R2 below low limit", int'(cell_status[0 +: 3]), 4);
        check("R2 above high limit", int'(cell_status[3*3 +: 3]), 4);
        check("R10 on-target after calibration", int'(cell_status[5*3 +: 3]), 1);
        check("R10 zero open-loop pulses", snap[2][5] - snap[1][5], 0);
        check("R9 disabled cell status", int'(cell_status[4*3 +: 3]), 0);
    endtask

    initial begin
        n_chk = 0; n_bad = 0; wait_n = 0; model_rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_nominal(1'b0);
        t_mismatch();
        t_edges();
        t_nominal(1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule